// File: doc/BRIEF.md
# Vertex Attribute Fetch Address Generator

This block walks a draw call vertex by vertex. For each vertex it issues one memory read for every component of every enabled input attribute. Each attribute has its own base address, stride, component count and data format. The read address is the attribute base, plus the stride times the vertex number, plus the component number times the element size. The element size comes from the format.

In indexed mode, each vertex first reads its vertex number from an index buffer, whose entries are 8 or 16 bits wide. That number then drives the attribute address arithmetic. Reads go out on a valid/ready request channel and come back on a response strobe. Each attribute response is converted to a 32-bit value, tagged with its attribute and component, and the end of the draw is marked by a single-cycle pulse.

Configuration must stay stable from the start pulse until the done pulse. Only one read is outstanding at a time.

Top module: `vaf_fetch_gen`

## Requirements
- R1: After reset, req_valid, val_valid and done are all low.
- R2: The attribute read address is base + stride * vnum + comp * size. The size is 1 for format code 0 (signed byte), 1 for code 1 (unsigned byte), 2 for code 2 (signed 16-bit) and 4 for code 3 (32-bit word), and req_size carries it.
- R3: Within a draw, vertices go from 0 to vertex_count - 1. Within each vertex, attributes go in ascending order, and components go in ascending order within an attribute. An attribute whose count field is 0 issues no read.
- R4: A component count field above 4 fetches exactly 4 components (0 to 3).
- R5: When indexed is high, each vertex starts with one read at idx_base + idx_offset + i * w, where w is 2 when idx_wide is high and 1 otherwise. This read has req_is_index high and req_size equal to w. The zero-extended low 16 bits (wide) or low 8 bits (narrow) of its response become vnum, and the response raises no val_valid.
- R6: A request keeps its address and size while req_ready is low. After a handshake no new request appears until rsp_valid has been seen on a later cycle.
- R7: In the cycle an attribute response arrives, val_valid is high with val_attr and val_comp naming the read. val_data is rsp_data[7:0] sign-extended for code 0, zero-extended for code 1, rsp_data[15:0] sign-extended for code 2, and rsp_data unchanged for code 3.
- R8: done is high for exactly one cycle, in the cycle after the last response is accepted. If vertex_count is 0, or the draw is not indexed and no attribute is enabled, done rises in the cycle after start and no read is issued.
- R9: A start pulse while a draw is in progress has no effect: the running sequence is unchanged and no second draw follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a draw (sampled when idle) |
| vertex_count | input | VTX_W | Number of vertices in the draw |
| indexed | input | 1 | Fetch vertex numbers through the index buffer |
| idx_base | input | ADDR_W | Index buffer base address |
| idx_offset | input | ADDR_W | Offset added to the index buffer base |
| idx_wide | input | 1 | Index entries are 16 bits (else 8 bits) |
| attr_base | input | NUM_ATTR*ADDR_W | Per-attribute base address, attribute k at bits [k*ADDR_W +: ADDR_W] |
| attr_stride | input | NUM_ATTR*STRIDE_W | Per-attribute stride in bytes |
| attr_count | input | NUM_ATTR*CNT_W | Per-attribute component count |
| attr_fmt | input | NUM_ATTR*2 | Per-attribute format code |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Read byte address |
| req_size | output | 3 | Read size in bytes (1, 2 or 4) |
| req_is_index | output | 1 | Request is an index buffer read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Raw read data, right-aligned |
| val_valid | output | 1 | Converted attribute value valid |
| val_data | output | 32 | Converted attribute value |
| val_attr | output | AIDX_W | Attribute of the value |
| val_comp | output | COMP_W | Component of the value |
| done | output | 1 | Draw finished (one-cycle pulse) |

## Verification
The response that completes the last enabled attribute of a vertex also moves the walk to the next vertex. So in one cycle the block must skip any trailing and leading zero-count attributes and either wrap the vertex number or end the draw. The same merge happens in indexed mode, where an index response both loads the vertex number and selects the first enabled attribute.

These cases are provoked with configurations whose first and last attributes have a count of 0, with an over-range count, and with stalls on the request channel. The bench judges them by comparing every request address, size and kind, and every converted value, in exact order against a sequence computed independently. It also checks that done lands in the cycle after the final response.

// File: rtl/vaf_pkg.sv
// Shared types for the vertex attribute fetch block.
// Assumes format codes are fixed by the requirements (0..3).
package vaf_pkg;

    typedef enum logic [1:0] {
        FMT_S8  = 2'd0,
        FMT_U8  = 2'd1,
        FMT_S16 = 2'd2,
        FMT_W32 = 2'd3
    } vaf_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDX_REQ,
        ST_IDX_WAIT,
        ST_ATT_REQ,
        ST_ATT_WAIT,
        ST_DONE
    } vaf_state_e;

    // Byte size of one element of the given format.
    function automatic logic [2:0] fmt_size(vaf_fmt_e f);
        case (f)
            FMT_S16: fmt_size = 3'd2;
            FMT_W32: fmt_size = 3'd4;
            default: fmt_size = 3'd1;
        endcase
    endfunction

    // log2 of the element size, used to scale the component number.
    function automatic logic [1:0] fmt_shift(vaf_fmt_e f);
        case (f)
            FMT_S16: fmt_shift = 2'd1;
            FMT_W32: fmt_shift = 2'd2;
            default: fmt_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/vaf_attr_select.sv
// Finds the lowest enabled attribute and the lowest enabled attribute
// above the current one. An attribute is enabled when its count is nonzero.
// Purely combinational; assumes the counts are stable during a draw.
module vaf_attr_select #(
    parameter int NUM_ATTR = 4,
    parameter int CNT_W    = 3,
    parameter int AIDX_W   = 2
) (
    input  logic [NUM_ATTR*CNT_W-1:0] cnt_flat,
    input  logic [AIDX_W-1:0]         cur,
    output logic                      any_en,
    output logic [AIDX_W-1:0]         first_idx,
    output logic                      has_next,
    output logic [AIDX_W-1:0]         next_idx
);
    logic [NUM_ATTR-1:0] en;

    // One enable bit per attribute slot.
    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_en
        assign en[g] = |cnt_flat[g*CNT_W +: CNT_W];
    end

    // Scan downward so the lowest matching slot wins.
    always_comb begin
        any_en    = |en;
        first_idx = '0;
        has_next  = 1'b0;
        next_idx  = '0;
        for (int k = NUM_ATTR - 1; k >= 0; k--) begin
            if (en[k]) begin
                first_idx = AIDX_W'(k);
                if (k > int'(cur)) begin
                    has_next = 1'b1;
                    next_idx = AIDX_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/vaf_addr_gen.sv
// Forms the byte address and size of the current read, either an index
// buffer entry or an attribute component. Combinational; wraps modulo 2^ADDR_W.
module vaf_addr_gen
    import vaf_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 8,
    parameter int VTX_W    = 16,
    parameter int COMP_W   = 2
) (
    input  logic                is_index,
    input  logic [ADDR_W-1:0]   idx_base,
    input  logic [ADDR_W-1:0]   idx_offset,
    input  logic                idx_wide,
    input  logic [VTX_W-1:0]    vtx_seq,
    input  logic [ADDR_W-1:0]   a_base,
    input  logic [STRIDE_W-1:0] a_stride,
    input  vaf_fmt_e            a_fmt,
    input  logic [VTX_W-1:0]    vnum,
    input  logic [COMP_W-1:0]   comp,
    output logic [ADDR_W-1:0]   addr,
    output logic [2:0]          size
);
    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] att_addr;

    // Index entry address: entry number scaled by the entry width.
    always_comb begin
        idx_addr = idx_base + idx_offset
                 + (ADDR_W'(vtx_seq) << (idx_wide ? 1 : 0));
    end

    // Attribute component address: base + stride * vnum + comp * elem size.
    always_comb begin
        att_addr = a_base + ADDR_W'(a_stride) * ADDR_W'(vnum)
                 + (ADDR_W'(comp) << fmt_shift(a_fmt));
    end

    // Select the active kind of read.
    always_comb begin
        addr = is_index ? idx_addr : att_addr;
        size = is_index ? (idx_wide ? 3'd2 : 3'd1) : fmt_size(a_fmt);
    end
endmodule

// File: rtl/vaf_convert.sv
// Widens raw read data to 32 bits according to the attribute format:
// sign or zero extension of bytes, sign extension of halfwords, words pass.
module vaf_convert
    import vaf_pkg::*;
(
    input  vaf_fmt_e    fmt,
    input  logic [31:0] raw,
    output logic [31:0] value
);
    // Extension chosen by format code.
    always_comb begin
        case (fmt)
            FMT_S8:  value = {{24{raw[7]}}, raw[7:0]};
            FMT_U8:  value = {24'd0, raw[7:0]};
            FMT_S16: value = {{16{raw[15]}}, raw[15:0]};
            default: value = raw;
        endcase
    end
endmodule

// File: rtl/vaf_fetch_gen.sv
// Vertex attribute fetch address generator.
// Walks vertices 0..vertex_count-1. For each, it optionally reads an index
// entry, then reads every component of each enabled attribute in ascending
// order. One read is outstanding at a time. Assumes the configuration inputs
// are stable from start to done, that VTX_W >= 16, and that responses
// arrive in a cycle after the request handshake.
module vaf_fetch_gen
    import vaf_pkg::*;
#(
    parameter int NUM_ATTR = 4,
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 8,
    parameter int VTX_W    = 16,
    parameter int MAX_COMP = 4,
    localparam int CNT_W   = $clog2(MAX_COMP + 1),
    localparam int COMP_W  = (MAX_COMP > 1) ? $clog2(MAX_COMP) : 1,
    localparam int AIDX_W  = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [VTX_W-1:0]             vertex_count,
    input  logic                         indexed,
    input  logic [ADDR_W-1:0]            idx_base,
    input  logic [ADDR_W-1:0]            idx_offset,
    input  logic                         idx_wide,
    input  logic [NUM_ATTR*ADDR_W-1:0]   attr_base,
    input  logic [NUM_ATTR*STRIDE_W-1:0] attr_stride,
    input  logic [NUM_ATTR*CNT_W-1:0]    attr_count,
    input  logic [NUM_ATTR*2-1:0]        attr_fmt,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [ADDR_W-1:0]            req_addr,
    output logic [2:0]                   req_size,
    output logic                         req_is_index,
    input  logic                         rsp_valid,
    input  logic [31:0]                  rsp_data,
    output logic                         val_valid,
    output logic [31:0]                  val_data,
    output logic [AIDX_W-1:0]            val_attr,
    output logic [COMP_W-1:0]            val_comp,
    output logic                         done
);
    vaf_state_e          st, st_n;
    logic [VTX_W-1:0]    vseq, vseq_n;     // sequential vertex counter
    logic [VTX_W-1:0]    vnum, vnum_n;     // vertex number used for addressing
    logic [AIDX_W-1:0]   cur_attr, attr_n;
    logic [COMP_W-1:0]   cur_comp, comp_n;

    logic                any_en, has_next;
    logic [AIDX_W-1:0]   first_idx, next_idx;
    logic [CNT_W-1:0]    cur_cnt, eff_cnt;
    vaf_fmt_e            cur_fmt;
    logic                last_comp, last_vtx, step_vtx;

    vaf_attr_select #(
        .NUM_ATTR (NUM_ATTR),
        .CNT_W    (CNT_W),
        .AIDX_W   (AIDX_W)
    ) u_sel (
        .cnt_flat  (attr_count),
        .cur       (cur_attr),
        .any_en    (any_en),
        .first_idx (first_idx),
        .has_next  (has_next),
        .next_idx  (next_idx)
    );

    // Fields of the attribute being fetched, with count clamped to MAX_COMP.
    always_comb begin
        cur_cnt   = attr_count[cur_attr*CNT_W +: CNT_W];
        cur_fmt   = vaf_fmt_e'(attr_fmt[cur_attr*2 +: 2]);
        eff_cnt   = (cur_cnt > CNT_W'(MAX_COMP)) ? CNT_W'(MAX_COMP) : cur_cnt;
        last_comp = (CNT_W'(cur_comp) + CNT_W'(1)) >= eff_cnt;
        last_vtx  = (vseq == vertex_count - VTX_W'(1));
    end

    vaf_addr_gen #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .VTX_W    (VTX_W),
        .COMP_W   (COMP_W)
    ) u_addr (
        .is_index   (st == ST_IDX_REQ),
        .idx_base   (idx_base),
        .idx_offset (idx_offset),
        .idx_wide   (idx_wide),
        .vtx_seq    (vseq),
        .a_base     (attr_base[cur_attr*ADDR_W +: ADDR_W]),
        .a_stride   (attr_stride[cur_attr*STRIDE_W +: STRIDE_W]),
        .a_fmt      (cur_fmt),
        .vnum       (vnum),
        .comp       (cur_comp),
        .addr       (req_addr),
        .size       (req_size)
    );

    vaf_convert u_conv (
        .fmt   (cur_fmt),
        .raw   (rsp_data),
        .value (val_data)
    );

    // Next-state logic of the walk: index read, component reads, vertex step.
    always_comb begin
        st_n     = st;
        vseq_n   = vseq;
        vnum_n   = vnum;
        attr_n   = cur_attr;
        comp_n   = cur_comp;
        step_vtx = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                vseq_n = '0;
                vnum_n = '0;
                attr_n = first_idx;
                comp_n = '0;
                if (vertex_count == '0 || (!indexed && !any_en)) st_n = ST_DONE;
                else st_n = indexed ? ST_IDX_REQ : ST_ATT_REQ;
            end
            ST_IDX_REQ:  if (req_ready) st_n = ST_IDX_WAIT;
            ST_IDX_WAIT: if (rsp_valid) begin
                vnum_n = idx_wide ? VTX_W'(rsp_data[15:0]) : VTX_W'(rsp_data[7:0]);
                attr_n = first_idx;
                comp_n = '0;
                if (any_en) st_n = ST_ATT_REQ;
                else step_vtx = 1'b1;
            end
            ST_ATT_REQ:  if (req_ready) st_n = ST_ATT_WAIT;
            ST_ATT_WAIT: if (rsp_valid) begin
                if (!last_comp) begin
                    comp_n = cur_comp + COMP_W'(1);
                    st_n   = ST_ATT_REQ;
                end else if (has_next) begin
                    attr_n = next_idx;
                    comp_n = '0;
                    st_n   = ST_ATT_REQ;
                end else begin
                    step_vtx = 1'b1;
                end
            end
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
        if (step_vtx) begin
            if (last_vtx) begin
                st_n = ST_DONE;
            end else begin
                vseq_n = vseq + VTX_W'(1);
                vnum_n = vseq + VTX_W'(1);
                attr_n = first_idx;
                comp_n = '0;
                st_n   = indexed ? ST_IDX_REQ : ST_ATT_REQ;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            vseq     <= '0;
            vnum     <= '0;
            cur_attr <= '0;
            cur_comp <= '0;
        end else begin
            st       <= st_n;
            vseq     <= vseq_n;
            vnum     <= vnum_n;
            cur_attr <= attr_n;
            cur_comp <= comp_n;
        end
    end

    // Port outputs decoded from the walk state.
    always_comb begin
        req_valid    = (st == ST_IDX_REQ) || (st == ST_ATT_REQ);
        req_is_index = (st == ST_IDX_REQ);
        val_valid    = (st == ST_ATT_WAIT) && rsp_valid;
        val_attr     = cur_attr;
        val_comp     = cur_comp;
        done         = (st == ST_DONE);
    end
endmodule

// File: rtl/vaf_fetch_gen_chk.sv
// Protocol checker for vaf_fetch_gen, attached by bind below.
// Observes ports only.
module vaf_fetch_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic              req_is_index,
    input logic              idx_wide,
    input logic              val_valid,
    input logic              done
);
    // R6: a stalled request holds its address and size.
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_size));

    // R6: only one read outstanding.
    a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid);

    // R2: read size is one of 1, 2, 4 bytes.
    a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_size) == 1) && (req_size != 3'd0));

    // R5: index reads use the selected entry width.
    a_r5_index_size: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_is_index |-> req_size == (idx_wide ? 3'd2 : 3'd1));

    // R8: done lasts a single cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: nothing else is active when done is raised.
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !val_valid);
endmodule

bind vaf_fetch_gen vaf_fetch_gen_chk #(.ADDR_W(ADDR_W)) u_vaf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_is_index (req_is_index),
    .idx_wide     (idx_wide),
    .val_valid    (val_valid),
    .done         (done)
);

// File: tb/vaf_fetch_gen_tb.sv
// Directed bench for vaf_fetch_gen: one task per scenario, each checking
// its own request stream, converted values and done timing.
module vaf_fetch_gen_tb_top;
    localparam int NA = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       vertex_count = '0;
    logic              indexed = 1'b0;
    logic [31:0]       idx_base = '0;
    logic [31:0]       idx_offset = '0;
    logic              idx_wide = 1'b0;
    logic [NA*32-1:0]  p_base;
    logic [NA*8-1:0]   p_stride;
    logic [NA*3-1:0]   p_cnt;
    logic [NA*2-1:0]   p_fmt;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [31:0]       req_addr;
    logic [2:0]        req_size;
    logic              req_is_index;
    logic              rsp_valid = 1'b0;
    logic [31:0]       rsp_data = '0;
    logic              val_valid;
    logic [31:0]       val_data;
    logic [1:0]        val_attr;
    logic [1:0]        val_comp;
    logic              done;

    logic [31:0] cfg_base   [NA];
    logic [7:0]  cfg_stride [NA];
    logic [2:0]  cfg_cnt    [NA];
    logic [1:0]  cfg_fmt    [NA];
    logic [15:0] idx_tab    [8];

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Pack per-attribute configuration into the flat ports.
    always_comb begin
        for (int k = 0; k < NA; k++) begin
            p_base[k*32 +: 32] = cfg_base[k];
            p_stride[k*8 +: 8] = cfg_stride[k];
            p_cnt[k*3 +: 3]    = cfg_cnt[k];
            p_fmt[k*2 +: 2]    = cfg_fmt[k];
        end
    end

    vaf_fetch_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vertex_count(vertex_count),
        .indexed(indexed), .idx_base(idx_base), .idx_offset(idx_offset),
        .idx_wide(idx_wide), .attr_base(p_base), .attr_stride(p_stride),
        .attr_count(p_cnt), .attr_fmt(p_fmt), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
        .req_is_index(req_is_index), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .val_valid(val_valid), .val_data(val_data), .val_attr(val_attr),
        .val_comp(val_comp), .done(done)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [2:0] f_size(input logic [1:0] f);
        return (f == 2'd3) ? 3'd4 : (f == 2'd2) ? 3'd2 : 3'd1;
    endfunction

    function automatic logic [31:0] f_ext(input logic [1:0] f, input logic [31:0] d);
        case (f)
            2'd0:    return {{24{d[7]}}, d[7:0]};
            2'd1:    return {24'd0, d[7:0]};
            2'd2:    return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    // Serve one read: check it, optionally stall, accept, respond.
    task automatic serve(input string rq, input bit is_idx, input logic [31:0] ea,
                         input logic [2:0] es, input logic [31:0] d, input int stall,
                         input bit poke, input int a, input int c, input logic [1:0] f);
        int w = 0;
        while (!req_valid && w < 50) begin @(negedge clk); w++; end
        chk(rq, "req_valid", 32'(req_valid), 32'd1);
        chk(rq, "req_addr", req_addr, ea);
        chk(rq, "req_size", 32'(req_size), 32'(es));
        chk(rq, "req_is_index", 32'(req_is_index), 32'(is_idx));
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R6", "stalled valid", 32'(req_valid), 32'd1);
            chk("R6", "stalled addr", req_addr, ea);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R6", "no request while waiting", 32'(req_valid), 32'd0);
        rsp_valid = 1'b1;
        rsp_data  = d;
        start     = poke;
        #1;
        if (is_idx) begin
            chk("R5", "index response val_valid", 32'(val_valid), 32'd0);
        end else begin
            chk("R7", "val_valid", 32'(val_valid), 32'd1);
            chk("R7", "val_data", val_data, f_ext(f, d));
            chk("R7", "val_attr", 32'(val_attr), 32'(a));
            chk("R7", "val_comp", 32'(val_comp), 32'(c));
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        start     = 1'b0;
    endtask

    // Run a whole draw against the bench's own model of the sequence.
    task automatic run_draw(input string rq, input int stall, input bit poke);
        int step = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < int'(vertex_count); i++) begin
            int vn = i;
            if (indexed) begin
                logic [31:0] d;
                d = idx_wide ? (32'hBEEF0000 | 32'(idx_tab[i]))
                             : (32'hABCDEF00 | 32'(idx_tab[i][7:0]));
                serve("R5", 1'b1, idx_base + idx_offset + 32'(i * (idx_wide ? 2 : 1)),
                      idx_wide ? 3'd2 : 3'd1, d,
                      (stall > 0 && step % 3 == 1) ? stall : 0, poke, 0, 0, 2'd0);
                vn = idx_wide ? int'(idx_tab[i]) : int'(idx_tab[i][7:0]);
                step++;
            end
            for (int a = 0; a < NA; a++) begin
                int n = (cfg_cnt[a] > 3'd4) ? 4 : int'(cfg_cnt[a]);
                for (int c = 0; c < n; c++) begin
                    logic [2:0] sz = f_size(cfg_fmt[a]);
                    logic [31:0] ea;
                    ea = cfg_base[a] + 32'(cfg_stride[a]) * 32'(vn) + 32'(c) * 32'(sz);
                    serve(rq, 1'b0, ea, sz, 32'h9E3779B9 * 32'(step + 1),
                          (stall > 0 && step % 3 == 1) ? stall : 0, poke, a, c, cfg_fmt[a]);
                    step++;
                end
            end
        end
        chk("R8", "done after last response", 32'(done), 32'd1);
        @(negedge clk);
        chk("R8", "done single cycle", 32'(done), 32'd0);
        for (int q = 0; q < 3; q++) begin
            @(negedge clk);
            chk("R9", "quiet after draw", 32'(req_valid | done), 32'd0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "req_valid in reset", 32'(req_valid), 32'd0);
        chk("R1", "val_valid in reset", 32'(val_valid), 32'd0);
        chk("R1", "done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", 32'(req_valid | done), 32'd0);
    endtask

    // R2 R3 R7: plain draw, all four formats, no stalls.
    task automatic t_plain();
        cfg_base   = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
        cfg_stride = '{8'd12, 8'd4, 8'd3, 8'd1};
        cfg_cnt    = '{3'd3, 3'd2, 3'd3, 3'd1};
        cfg_fmt    = '{2'd3, 2'd2, 2'd0, 2'd1};
        indexed = 1'b0; vertex_count = 16'd3;
        run_draw("R2 R3", 0, 1'b0);
    endtask

    // R3 R4 R5: narrow index entries, zero-count edge slots, clamped count, stalls.
    task automatic t_idx8();
        cfg_base   = '{32'h8000, 32'h9000, 32'hA000, 32'hB000};
        cfg_stride = '{8'd16, 8'd2, 8'd8, 8'd5};
        cfg_cnt    = '{3'd0, 3'd2, 3'd0, 3'd7};
        cfg_fmt    = '{2'd3, 2'd0, 2'd2, 2'd1};
        idx_tab    = '{16'h0007, 16'h00F2, 16'h0000, 16'h0031, 16'h0, 16'h0, 16'h0, 16'h0};
        indexed = 1'b1; idx_wide = 1'b0; idx_base = 32'h0005_0000; idx_offset = 32'h13;
        vertex_count = 16'd4;
        run_draw("R3 R4", 2, 1'b0);
    endtask

    // R5 R9: wide index entries, single attribute, start poked while busy.
    task automatic t_idx16();
        cfg_base   = '{32'h0, 32'h0, 32'hC000_0000, 32'h0};
        cfg_stride = '{8'd0, 8'd0, 8'd200, 8'd0};
        cfg_cnt    = '{3'd0, 3'd0, 3'd1, 3'd0};
        cfg_fmt    = '{2'd0, 2'd0, 2'd3, 2'd0};
        idx_tab    = '{16'h1234, 16'hFFFF, 16'h0100, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
        indexed = 1'b1; idx_wide = 1'b1; idx_base = 32'h0006_0000; idx_offset = 32'h2;
        vertex_count = 16'd3;
        run_draw("R5 R9", 1, 1'b1);
    endtask

    // R8: empty draws finish immediately; indexed with no attributes reads indices only.
    task automatic t_empty();
        cfg_cnt = '{3'd0, 3'd0, 3'd0, 3'd0};
        indexed = 1'b0; vertex_count = 16'd5;
        run_draw("R8", 0, 1'b0);
        cfg_cnt = '{3'd1, 3'd1, 3'd1, 3'd1};
        vertex_count = 16'd0;
        run_draw("R8", 0, 1'b0);
        cfg_cnt = '{3'd0, 3'd0, 3'd0, 3'd0};
        indexed = 1'b1; idx_wide = 1'b0; vertex_count = 16'd2;
        run_draw("R8", 0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cfg_base   = '{32'h0, 32'h0, 32'h0, 32'h0};
        cfg_stride = '{8'd0, 8'd0, 8'd0, 8'd0};
        cfg_cnt    = '{3'd0, 3'd0, 3'd0, 3'd0};
        cfg_fmt    = '{2'd0, 2'd0, 2'd0, 2'd0};
        idx_tab    = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
        t_reset();
        t_plain();
        t_idx8();
        t_idx16();
        t_empty();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule